// File: doc/BRIEF.md
# Synchronous Memory Write-Enable and Output Control

This block is the control front end of a flow-through synchronous memory that stores words of two 9-bit byte lanes. Three write controls are combined into one write enable per lane, in priority order. An active-low global write forces a full-word write. When the global control is inactive, an active-low byte-write enable passes the two per-lane strobes through. The cycle counts as a read when no lane is asked to write.

The block also decides when the bidirectional data bus is driven. Drive happens only when the asynchronous output enable is low, the address unit reports the device selected, and the cycle is a read. Read data passes through combinationally with no output register, so it appears in the same cycle as the address.

An asynchronous snooze input deselects the device, blocks all inputs and turns the bus drive off. The array keeps its contents during snooze. After snooze falls, a recovery window of `WAKE_CYC` clock edges follows. In that window reads are served, but any write attempt is refused and reported on an error output.

Top module: `sram_wr_ctrl`

## Requirements
- R1: With `gw_n` low, the device selected and no snooze or wake window, `lane_we` is 2'b11 whatever `bwe_n` and `lane_n` are.
- R2: With `gw_n` high and `bwe_n` low, each bit of `lane_we` is the inverse of the matching bit of `lane_n` (bit 0 = data bits 8:0, bit 1 = data bits 17:9), given selection and no snooze or wake window.
- R3: With `gw_n` high and `bwe_n` high, no lane is written and the cycle is a read, whatever `lane_n` is.
- R4: `dq_oe` is 1 exactly when `oe_n` is low, `sel` is high, `snooze` is low and no lane write is requested.
- R5: While `dq_oe` is 1, `dq_out` equals `rd_data` in the same cycle with no register stage; otherwise `dq_out` is zero.
- R6: With `sel` low, `lane_we` is 0 and `dq_oe` is 0.
- R7: With `snooze` high, `lane_we`, `dq_oe`, `wr_data` and `wake_err` are all 0, whatever the other inputs are.
- R8: After `snooze` falls, any requested write is suppressed (`lane_we` = 0) and `wake_err` is 1 until `WAKE_CYC` rising clock edges have sampled `snooze` low. Reads are still driven in this window.
- R9: Once that window has passed, and from reset with no snooze seen, writes are granted normally and `wake_err` stays 0.
- R10: `wr_data` carries the lanes of `dq_in` whose `lane_we` bit is set, with the other lanes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Device selected, from the address unit |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 2 | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Asynchronous power-down request, active high |
| dq_in | input | 18 | Write data from the bus |
| rd_data | input | 18 | Read data from the array |
| lane_we | output | 2 | Per-lane write enables to the array |
| wr_data | output | 18 | Lane-masked write data to the array |
| dq_out | output | 18 | Data toward the bus pads |
| dq_oe | output | 1 | Bus drive enable |
| wake_err | output | 1 | Write attempted during the wake window |

## Verification
The bench builds the block with its defaults: two 9-bit lanes and `WAKE_CYC` = 4. With a short window, every count of post-snooze edges up to and beyond the limit can be reached, so the random stream often lands on the window boundary. With two lanes, all four strobe patterns under each of the global and byte-enable settings are covered within a few hundred random cycles.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Requested write on one lane, before selection, snooze and wake gating.
  function automatic logic lane_request(input logic gw_n, input logic bwe_n,
                                        input logic strobe_n);
    if (!gw_n)       return 1'b1;
    else if (!bwe_n) return ~strobe_n;
    else             return 1'b0;
  endfunction

  // Next value of the wake-recovery countdown.
  function automatic int unsigned wake_next(input logic snooze, input int unsigned cnt,
                                            input int unsigned limit);
    if (snooze)        return limit;
    else if (cnt != 0) return cnt - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/sram_we_decode.sv
module sram_we_decode #(
  parameter int LANES = 2
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] req_we
);
  import sram_ctl_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign req_we[g] = lane_request(gw_n, bwe_n, lane_n[g]);
  end
endmodule

// File: rtl/sram_wake_timer.sv
module sram_wake_timer #(
  parameter int WAKE_CYC = 4,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snooze,
  output logic             waking,
  output logic [CNT_W-1:0] cnt
);
  import sram_ctl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(wake_next(snooze, int'(cnt), WAKE_CYC));
  end

  assign waking = !snooze && (cnt != '0);
endmodule

// File: rtl/sram_out_gate.sv
module sram_out_gate #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    drive,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic [LANES*LANE_W-1:0] rd_data,
  output logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] dq_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_data[g*LANE_W +: LANE_W] = lane_we[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    assign dq_out[g*LANE_W +: LANE_W]  = drive ? rd_data[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 4,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int CNT_W   = $clog2(WAKE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              oe_n,
  input  logic              snooze,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              wake_err
);
  // Named internal events, visible to the bound checker.
  logic [LANES-1:0] req_we;
  logic             waking;
  logic [CNT_W-1:0] wake_cnt;
  logic             active;
  logic             wr_req;
  logic             is_read;

  sram_we_decode #(.LANES(LANES)) u_dec (
    .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n), .req_we(req_we)
  );

  sram_wake_timer #(.WAKE_CYC(WAKE_CYC), .CNT_W(CNT_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .waking(waking), .cnt(wake_cnt)
  );

  assign active   = sel && !snooze;
  assign wr_req   = |req_we;
  assign is_read  = !wr_req;
  assign lane_we  = (active && !waking) ? req_we : '0;
  assign wake_err = active && waking && wr_req;
  assign dq_oe    = active && is_read && !oe_n;

  sram_out_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .drive(dq_oe), .lane_we(lane_we), .dq_in(dq_in), .rd_data(rd_data),
    .wr_data(wr_data), .dq_out(dq_out)
  );
endmodule

// File: rtl/sram_wr_ctrl_chk.sv
module sram_wr_ctrl_chk #(
  parameter int LANES = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             oe_n,
  input logic             snooze,
  input logic [LANES-1:0] lane_we,
  input logic             dq_oe,
  input logic             wake_err,
  input logic             waking,
  input logic [CNT_W-1:0] wake_cnt
);
  a_r7_snooze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> (lane_we == '0) && !dq_oe && !wake_err);

  a_r6_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (lane_we == '0) && !dq_oe);

  a_r4_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (lane_we == '0) && sel && !oe_n);

  a_r8_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> (lane_we == '0));

  a_r8_err_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |-> waking);

  a_r9_window_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && wake_cnt != '0) |=> (wake_cnt < $past(wake_cnt)) || snooze);
endmodule

bind sram_wr_ctrl sram_wr_ctrl_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .oe_n(oe_n), .snooze(snooze),
  .lane_we(lane_we), .dq_oe(dq_oe), .wake_err(wake_err),
  .waking(waking), .wake_cnt(wake_cnt)
);

// File: tb/tb_sram_wr_ctrl.sv
module tb_sram_wr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 4;

  logic        clk = 0, rst_n = 0;
  logic        sel = 0, gw_n = 1, bwe_n = 1, oe_n = 1, snooze = 0;
  logic [1:0]  lane_n = 2'b11;
  logic [17:0] dq_in = '0, rd_data = '0;
  logic [1:0]  lane_we;
  logic [17:0] wr_data, dq_out;
  logic        dq_oe, wake_err;

  int n_chk = 0, n_fail = 0;
  int low_edges = WAKE;

  sram_wr_ctrl #(.LANES(2), .LANE_W(9), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_n(lane_n), .oe_n(oe_n), .snooze(snooze), .dq_in(dq_in),
    .rd_data(rd_data), .lane_we(lane_we), .wr_data(wr_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .wake_err(wake_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of the wake window: posedges that sampled snooze low since it was last high.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_edges <= WAKE;
    else if (snooze) low_edges <= 0;
    else if (low_edges < WAKE) low_edges <= low_edges + 1;
  end

  function automatic logic [1:0] want_we();
    if (!gw_n)  return 2'b11;
    if (!bwe_n) return ~lane_n;
    return 2'b00;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [1:0]  rq   = want_we();
    logic        on   = sel && !snooze;
    logic        win  = !snooze && (low_edges < WAKE);
    logic [1:0]  we   = (on && !win) ? rq : 2'b00;
    logic        oe   = on && (rq == 2'b00) && !oe_n;
    logic [17:0] wd   = {we[1] ? dq_in[17:9] : 9'd0, we[0] ? dq_in[8:0] : 9'd0};
    cmp(req, "lane_we", 32'(lane_we), 32'(we));
    cmp(req, "dq_oe", 32'(dq_oe), 32'(oe));
    cmp(req, "dq_out", 32'(dq_out), 32'(oe ? rd_data : 18'd0));
    cmp(req, "wr_data", 32'(wr_data), 32'(wd));
    cmp(req, "wake_err", 32'(wake_err), 32'(on && win && (rq != 2'b00)));
  endtask

  task automatic set_in(logic s, logic g, logic b, logic [1:0] l, logic o, logic z);
    @(negedge clk);
    sel = s; gw_n = g; bwe_n = b; lane_n = l; oe_n = o; snooze = z;
    dq_in = 18'($urandom); rd_data = 18'($urandom);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    // Reset state: idle, nothing written or driven.
    cmp("R6", "reset lane_we", 32'(lane_we), 0);
    cmp("R6", "reset dq_oe", 32'(dq_oe), 0);
    cmp("R9", "reset wake_err", 32'(wake_err), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R9: no window after reset; R1 global write overrides strobes.
    set_in(1, 0, 1, 2'b11, 0, 0); check_all("R1");
    cmp("R1", "global lane_we", 32'(lane_we), 32'h3);
    // R2 each strobe pattern
    for (int p = 0; p < 4; p++) begin
      set_in(1, 1, 0, 2'(p), 1, 0); check_all("R2");
      cmp("R10", "masked wr_data", 32'(wr_data),
          32'({p[1] ? 9'd0 : dq_in[17:9], p[0] ? 9'd0 : dq_in[8:0]}));
    end
    // R3 byte enable off: read, driven
    set_in(1, 1, 1, 2'b00, 0, 0); check_all("R3");
    cmp("R3", "read drive", 32'(dq_oe), 1);
    cmp("R5", "flow-through data", 32'(dq_out), 32'(rd_data));
    // R4 read with oe_n high: not driven
    set_in(1, 1, 0, 2'b11, 1, 0); check_all("R4");
    cmp("R4", "oe_n high no drive", 32'(dq_oe), 0);
    // R6 deselected
    set_in(0, 0, 0, 2'b00, 0, 0); check_all("R6");
    // R7 snooze blocks everything
    set_in(1, 0, 0, 2'b00, 0, 1); check_all("R7");
    set_in(1, 1, 1, 2'b11, 0, 1); check_all("R7");
    cmp("R7", "snooze no drive", 32'(dq_oe), 0);
    // R8 window: a write is refused until WAKE edges have sampled snooze low
    for (int i = 0; i <= WAKE; i++) begin
      set_in(1, 0, 1, 2'b11, 1, 0);
      cmp(i < WAKE ? "R8" : "R9", "window lane_we", 32'(lane_we), i < WAKE ? 0 : 3);
      cmp(i < WAKE ? "R8" : "R9", "window err", 32'(wake_err), i < WAKE ? 1 : 0);
    end
    // R8 reads served in window
    set_in(1, 1, 1, 2'b00, 0, 1);
    set_in(1, 1, 1, 2'b00, 0, 0);
    cmp("R8", "read in window", 32'(dq_oe), 1);
    cmp("R8", "read data in window", 32'(dq_out), 32'(rd_data));

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int unsigned r = $urandom;
      set_in(r[0] | r[1], r[2] & r[3], r[4], 2'(r[6:5]), r[7] & r[8],
             (r[15:12] == 4'd0));
      check_all("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule